// File: doc/BRIEF.md
# Burst Transmit Chip Sequencer

This block produces the spread baseband chips of one transmit burst. A rising edge on either of two enable inputs (a pin-level enable or an enable bit written by software) starts a burst. The block first emits one preamble symbol, which is the preamble spreading code sent unmodulated. It then emits a programmed number of data symbols. Each data symbol is one full pass of a separate data spreading code, XORed with the data bit of that symbol in BPSK mode, or with each bit of a bit pair in QPSK mode. When the programmed symbol count is used up, the burst ends by itself.

Chip timing comes from a chip-enable strobe that is one clock wide. Each strobe during a burst advances the sequencer by one chip and updates the registered I and Q chip outputs. Input data is fetched with a bit-request handshake. The bits for a symbol are requested right after the last chip of the symbol before it, so they are held in registers before the symbol's first chip. Carrier modulation and differential encoding take place outside this block.

Top module: `burst_tx_seq`

## Requirements
- R1: A rising edge on `tx_en` or on `sw_en` starts a burst only while the block is idle. Holding either input high does not start another burst.
- R2: The preamble lasts `pre_len`+1 chips (1 to 64). Preamble chip c, counted from 0, equals `pre_code[c]` on both `chip_i` and `chip_q`.
- R3: Each data symbol lasts `dat_len`+1 chips. The chip index restarts at 0 in every symbol. Chip c is `dat_code[c]` XOR the symbol's I bit on `chip_i`; in QPSK mode, `chip_q` is `dat_code[c]` XOR the symbol's Q bit.
- R4: `pre_done` is high for exactly one clock, in the cycle after the strobe of the last preamble chip.
- R5: `bit_req` pulses once per data symbol in BPSK mode (`qpsk_mode`=0). In QPSK mode it pulses twice, with one low cycle between the pulses. The first pulse asks for the I bit and the second for the Q bit. `data_in` is sampled at the clock edge that ends each high cycle of `bit_req`. The pulses follow the strobe of the last chip of the preceding symbol, and none are issued after the final symbol.
- R6: In BPSK mode every data chip on `chip_q` equals the one on `chip_i`.
- R7: The burst ends after `num_syms` data symbols (16-bit count); a count of 0 sends the preamble only. `data_active` is high from the strobe of the last preamble chip until the strobe of the final data chip.
- R8: A start edge that arrives during a burst has no effect on the chip sequence.
- R9: The chip outputs change only on chip-enable strobes during a burst. While idle, strobes change nothing and raise no bit request.
- R10: After reset the block is idle and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Pin-level burst enable, rising-edge sensitive |
| sw_en | input | 1 | Software burst enable, rising-edge sensitive |
| chip_en | input | 1 | One-clock chip-rate strobe |
| qpsk_mode | input | 1 | 1 = QPSK (bit pairs), 0 = BPSK |
| pre_len | input | 6 | Preamble chips minus one |
| dat_len | input | 6 | Data symbol chips minus one |
| pre_code | input | 64 | Preamble code, bit c used for chip c |
| dat_code | input | 64 | Data code, bit c used for chip c |
| num_syms | input | 16 | Data symbols per burst |
| data_in | input | 1 | Serial data, sampled while bit_req is high |
| bit_req | output | 1 | Data bit request pulse |
| chip_i | output | 1 | Spread I chip |
| chip_q | output | 1 | Spread Q chip |
| pre_done | output | 1 | Preamble finished pulse |
| data_active | output | 1 | High while data symbols are being sent |

## Verification
The tests cover several cases. The longest case is a 64-chip preamble followed by one-chip QPSK symbols; a design with an off-by-one length compare drops or repeats a chip, or indexes past the code. A burst with a symbol count of zero must end after the preamble without any bit request; a sequencer that counts down from zero would run for 65536 symbols. A start edge during the preamble must leave the chip sequence intact; a design that honours it would restart at code bit 0. After the burst, strobes must not move the outputs, and an enable held high must not start a second burst. Any of these faults shows up as a wrong chip, a wrong request count or a stray pulse.

// File: rtl/burst_tx_pkg.sv
package burst_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_DATA = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        RQ_NONE = 2'd0,
        RQ_I    = 2'd1,
        RQ_GAP  = 2'd2,
        RQ_Q    = 2'd3
    } req_phase_e;

endpackage

// File: rtl/btx_start_detect.sv
module btx_start_detect #(
    parameter int N_SRC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] en_src,
    output logic             start
);
    typedef struct packed {
        logic [N_SRC-1:0] prev;
    } det_t;

    det_t det_d, det_q;
    logic [N_SRC-1:0] rise;

    for (genvar g = 0; g < N_SRC; g++) begin : g_rise
        assign rise[g] = en_src[g] & ~det_q.prev[g];
    end

    always_comb begin
        det_d      = det_q;
        det_d.prev = en_src;
        start      = |rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end
endmodule

// File: rtl/btx_code_sel.sv
module btx_code_sel #(
    parameter int CODE_LEN = 64,
    localparam int IDX_W   = $clog2(CODE_LEN)
) (
    input  logic [CODE_LEN-1:0] code,
    input  logic [IDX_W-1:0]    idx,
    output logic                code_bit
);
    always_comb begin
        code_bit = 1'b0;
        for (int k = 0; k < CODE_LEN; k++) begin
            if (idx == IDX_W'(k)) code_bit = code[k];
        end
    end
endmodule

// File: rtl/btx_bit_fetch.sv
module btx_bit_fetch
    import burst_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fetch,
    input  logic qpsk_mode,
    input  logic data_in,
    output logic bit_req,
    output logic sym_i,
    output logic sym_q
);
    typedef struct packed {
        req_phase_e phase;
        logic       sym_i;
        logic       sym_q;
    } fetch_t;

    fetch_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        unique case (f_q.phase)
            RQ_NONE: if (fetch) f_d.phase = RQ_I;
            RQ_I: begin
                f_d.sym_i = data_in;
                f_d.phase = qpsk_mode ? RQ_GAP : RQ_NONE;
            end
            RQ_GAP: f_d.phase = RQ_Q;
            RQ_Q: begin
                f_d.sym_q = data_in;
                f_d.phase = RQ_NONE;
            end
            default: f_d.phase = RQ_NONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{phase: RQ_NONE, sym_i: 1'b0, sym_q: 1'b0};
        else        f_q <= f_d;
    end

    assign bit_req = (f_q.phase == RQ_I) || (f_q.phase == RQ_Q);
    assign sym_i   = f_q.sym_i;
    assign sym_q   = f_q.sym_q;
endmodule

// File: rtl/burst_tx_seq.sv
module burst_tx_seq
    import burst_tx_pkg::*;
#(
    parameter int MAX_CHIPS = 64,
    parameter int SYM_W     = 16,
    localparam int IDX_W    = $clog2(MAX_CHIPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_en,
    input  logic                 sw_en,
    input  logic                 chip_en,
    input  logic                 qpsk_mode,
    input  logic [IDX_W-1:0]     pre_len,
    input  logic [IDX_W-1:0]     dat_len,
    input  logic [MAX_CHIPS-1:0] pre_code,
    input  logic [MAX_CHIPS-1:0] dat_code,
    input  logic [SYM_W-1:0]     num_syms,
    input  logic                 data_in,
    output logic                 bit_req,
    output logic                 chip_i,
    output logic                 chip_q,
    output logic                 pre_done,
    output logic                 data_active
);
    typedef struct packed {
        seq_state_e       state;
        logic [IDX_W-1:0] idx;
        logic [SYM_W-1:0] sym_cnt;
        logic             chip_i;
        logic             chip_q;
        logic             pre_done;
    } seq_t;

    seq_t s_d, s_q;

    logic             start;
    logic             pre_bit;
    logic             dat_bit;
    logic             sym_i;
    logic             sym_q;
    logic             fetch;
    logic [SYM_W-1:0] sym_nxt;

    btx_start_detect #(.N_SRC(2)) u_start (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_src ({sw_en, tx_en}),
        .start  (start)
    );

    btx_code_sel #(.CODE_LEN(MAX_CHIPS)) u_pre_sel (
        .code     (pre_code),
        .idx      (s_q.idx),
        .code_bit (pre_bit)
    );

    btx_code_sel #(.CODE_LEN(MAX_CHIPS)) u_dat_sel (
        .code     (dat_code),
        .idx      (s_q.idx),
        .code_bit (dat_bit)
    );

    btx_bit_fetch u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch     (fetch),
        .qpsk_mode (qpsk_mode),
        .data_in   (data_in),
        .bit_req   (bit_req),
        .sym_i     (sym_i),
        .sym_q     (sym_q)
    );

    assign sym_nxt = s_q.sym_cnt + 1'b1;

    always_comb begin
        s_d          = s_q;
        s_d.pre_done = 1'b0;
        fetch        = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (start) begin
                    s_d.state   = ST_PRE;
                    s_d.idx     = '0;
                    s_d.sym_cnt = '0;
                end
            end
            ST_PRE: begin
                if (chip_en) begin
                    s_d.chip_i = pre_bit;
                    s_d.chip_q = pre_bit;
                    if (s_q.idx == pre_len) begin
                        s_d.idx      = '0;
                        s_d.pre_done = 1'b1;
                        if (num_syms == '0) begin
                            s_d.state = ST_IDLE;
                        end else begin
                            s_d.state = ST_DATA;
                            fetch     = 1'b1;
                        end
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (chip_en) begin
                    s_d.chip_i = dat_bit ^ sym_i;
                    s_d.chip_q = dat_bit ^ (qpsk_mode ? sym_q : sym_i);
                    if (s_q.idx == dat_len) begin
                        s_d.idx = '0;
                        if (sym_nxt == num_syms) begin
                            s_d.state = ST_IDLE;
                        end else begin
                            s_d.sym_cnt = sym_nxt;
                            fetch       = 1'b1;
                        end
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: ST_IDLE, idx: '0, sym_cnt: '0,
                     chip_i: 1'b0, chip_q: 1'b0, pre_done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign chip_i      = s_q.chip_i;
    assign chip_q      = s_q.chip_q;
    assign pre_done    = s_q.pre_done;
    assign data_active = (s_q.state == ST_DATA);
endmodule

// File: rtl/btx_checker.sv
module btx_checker (
    input logic clk,
    input logic rst_n,
    input logic chip_en,
    input logic qpsk_mode,
    input logic bit_req,
    input logic chip_i,
    input logic chip_q,
    input logic pre_done,
    input logic data_active
);
    assert_pre_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pre_done |=> !pre_done);

    assert_data_starts_at_preamble_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_active) |-> pre_done);

    assert_req_within_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_req |-> data_active);

    assert_req_pulses_separate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_req |=> !bit_req);

    assert_bpsk_iq_equal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && data_active && !qpsk_mode) |=> (chip_i == chip_q));

    assert_chips_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |=> ($stable(chip_i) && $stable(chip_q)));
endmodule

bind burst_tx_seq btx_checker u_btx_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .chip_en     (chip_en),
    .qpsk_mode   (qpsk_mode),
    .bit_req     (bit_req),
    .chip_i      (chip_i),
    .chip_q      (chip_q),
    .pre_done    (pre_done),
    .data_active (data_active)
);

// File: tb/tb_burst_tx_seq.sv
`timescale 1ns/1ps
module tb_burst_tx_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0, sw_en = 1'b0, chip_en = 1'b0, qpsk_mode = 1'b0;
    logic [5:0]  pre_len = '0, dat_len = '0;
    logic [63:0] pre_code = '0, dat_code = '0;
    logic [15:0] num_syms = '0;
    logic        data_in = 1'b0;
    logic        bit_req, chip_i, chip_q, pre_done, data_active;

    int checks = 0;
    int errors = 0;
    int ptr = 0;
    localparam logic [127:0] STREAM = 128'h9E37_79B9_7F4A_7C15_D1B5_4A32_C3A5_0F6B;

    always #2.5 clk = ~clk;

    burst_tx_seq dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .sw_en(sw_en), .chip_en(chip_en),
        .qpsk_mode(qpsk_mode), .pre_len(pre_len), .dat_len(dat_len),
        .pre_code(pre_code), .dat_code(dat_code), .num_syms(num_syms),
        .data_in(data_in), .bit_req(bit_req), .chip_i(chip_i), .chip_q(chip_q),
        .pre_done(pre_done), .data_active(data_active)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic serve(inout int n);
        if (bit_req) begin
            data_in = STREAM[ptr];
            ptr++;
            n++;
        end
    endtask

    task automatic do_chip(output logic ci, output logic cq, output logic pd,
                           output logic da, output int nreq);
        nreq = 0;
        @(negedge clk) chip_en = 1'b1;
        @(negedge clk) chip_en = 1'b0;
        ci = chip_i; cq = chip_q; pd = pre_done; da = data_active;
        serve(nreq);
        repeat (5) begin
            @(negedge clk);
            serve(nreq);
        end
    endtask

    task automatic start_pulse(input bit use_sw);
        @(negedge clk);
        if (use_sw) sw_en = 1'b1; else tx_en = 1'b1;
        @(negedge clk);
        sw_en = 1'b0; tx_en = 1'b0;
    endtask

    task automatic run_burst(input bit q, input int pl, input int dl,
                             input logic [63:0] pc, input logic [63:0] dc,
                             input int ns, input bit use_sw, input bit retrig);
        logic ci, cq, pd, da;
        int   nreq;
        int   per;
        qpsk_mode = q; pre_len = 6'(pl); dat_len = 6'(dl);
        pre_code = pc; dat_code = dc; num_syms = 16'(ns);
        ptr = 0;
        per = q ? 2 : 1;
        start_pulse(use_sw);
        chk(data_active == 1'b0 && bit_req == 1'b0, "R1", "idle outputs after start",
            int'(data_active), 0);
        for (int c = 0; c <= pl; c++) begin
            if (retrig && c == 2) start_pulse(1'b0);
            do_chip(ci, cq, pd, da, nreq);
            chk(ci == pc[c], (retrig && c == 2) ? "R8" : "R2", "preamble chip_i", int'(ci), int'(pc[c]));
            chk(cq == pc[c], "R2", "preamble chip_q", int'(cq), int'(pc[c]));
            chk(pd == (c == pl), "R4", "pre_done", int'(pd), int'(c == pl));
            chk(da == (c == pl && ns != 0), "R7", "data_active in preamble", int'(da),
                int'(c == pl && ns != 0));
            chk(nreq == ((c == pl && ns != 0) ? per : 0), "R5", "requests after preamble chip",
                nreq, (c == pl && ns != 0) ? per : 0);
        end
        for (int s = 0; s < ns; s++) begin
            logic bi, bq;
            bi = q ? STREAM[2*s] : STREAM[s];
            bq = q ? STREAM[2*s+1] : bi;
            for (int c = 0; c <= dl; c++) begin
                bit last_sym, last;
                last_sym = (c == dl);
                last     = last_sym && (s == ns - 1);
                do_chip(ci, cq, pd, da, nreq);
                chk(ci == (dc[c] ^ bi), "R3", "data chip_i", int'(ci), int'(dc[c] ^ bi));
                chk(cq == (dc[c] ^ bq), q ? "R3" : "R6", "data chip_q", int'(cq), int'(dc[c] ^ bq));
                chk(pd == 1'b0, "R4", "pre_done during data", int'(pd), 0);
                chk(da == !last, "R7", "data_active", int'(da), int'(!last));
                chk(nreq == ((last_sym && !last) ? per : 0), "R5", "requests after data chip",
                    nreq, (last_sym && !last) ? per : 0);
            end
        end
        chk(ptr == ns * per, "R5", "total bits fetched", ptr, ns * per);
    endtask

    task automatic test_reset();
        chk(chip_i == 0 && chip_q == 0, "R10", "chips after reset", int'({chip_i, chip_q}), 0);
        chk(bit_req == 0 && pre_done == 0 && data_active == 0, "R10", "status after reset",
            int'({bit_req, pre_done, data_active}), 0);
    endtask

    task automatic test_idle_strobes();
        logic ci, cq, pd, da, ci0, cq0;
        int   nreq;
        ci0 = chip_i; cq0 = chip_q;
        for (int k = 0; k < 3; k++) begin
            do_chip(ci, cq, pd, da, nreq);
            chk(ci == ci0 && cq == cq0, "R9", "idle chips held", int'({ci, cq}), int'({ci0, cq0}));
            chk(nreq == 0 && da == 0 && pd == 0, "R9", "idle no activity", nreq + int'(da), 0);
        end
    endtask

    task automatic test_level_hold();
        logic ci, cq, pd, da, ci0, cq0;
        int   nreq;
        qpsk_mode = 1'b0; pre_len = 6'd3; pre_code = 64'h0000_0000_0000_000A;
        num_syms = 16'd0;
        @(negedge clk) tx_en = 1'b1;
        for (int c = 0; c <= 3; c++) do_chip(ci, cq, pd, da, nreq);
        chk(pd == 1'b1, "R1", "first burst finished", int'(pd), 1);
        ci0 = chip_i; cq0 = chip_q;
        for (int k = 0; k < 4; k++) begin
            do_chip(ci, cq, pd, da, nreq);
            chk(pd == 0 && ci == ci0 && cq == cq0, "R1", "held enable does not restart",
                int'({pd, ci, cq}), int'({1'b0, ci0, cq0}));
        end
        @(negedge clk) tx_en = 1'b0;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog run did not complete actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R2 R3 R5 R6: BPSK burst
        run_burst(1'b0, 4, 6, 64'h0000_0000_0000_0016, 64'h0000_0000_0000_0053, 5, 1'b0, 1'b0);
        // R3 R5: QPSK burst
        run_burst(1'b1, 2, 9, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_02C9, 6, 1'b1, 1'b0);
        // R2 boundary: 64-chip preamble, 1-chip QPSK symbols
        run_burst(1'b1, 63, 0, 64'hF0E1_D2C3_B4A5_9687, 64'h0000_0000_0000_0001, 4, 1'b0, 1'b0);
        // R7: zero symbols
        run_burst(1'b0, 5, 3, 64'h0000_0000_0000_002D, 64'h0000_0000_0000_0006, 0, 1'b0, 1'b0);
        // R8: retrigger during preamble
        run_burst(1'b1, 6, 2, 64'h0000_0000_0000_0074, 64'h0000_0000_0000_0003, 3, 1'b0, 1'b1);
        test_idle_strobes();
        test_level_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule